// File: doc/BRIEF.md
# Signed Down Counter with Sign-Magnitude Hex Readout

This block keeps a 12-bit two's complement count. The count steps down by one on every clock cycle in which the count enable is high, and holds in every other cycle. When the count passes its most negative value it wraps to the most positive value. A one-cycle overflow pulse marks that wrap.

The block also turns the count into a readout. It gives a sign flag and an unsigned magnitude, three active-low seven-segment codes for the hexadecimal magnitude digits, and a fourth code that shows either a minus sign or a blank. Counting down from zero, the readout goes 000, -001, ... -7FF, -800, then 7FF, 7FE, ... 001, 000, -001 and so on.

An external asynchronous active-low reset clears the count. The reset is released through an internal two-stage synchroniser, so the count starts moving on the third rising edge after the reset input goes high. Whoever instantiates the block supplies the clock division, any button conditioning and the board wiring.

Top module: `sdc_signed_down_counter`

## Requirements
- R1: While `rst_n` is low, the outputs are: count 000h, sign flag 0, magnitude 000h, overflow 0. This holds at once, without waiting for a clock edge. After `rst_n` goes high, the count holds 000h for the first two rising edges.
- R2: After reset has been released, each rising edge with `en` high sets the count to (count - 1) modulo 4096.
- R3: A rising edge with `en` low leaves the count unchanged.
- R4: `ovf_o` is high for exactly one cycle after an enabled edge that moves the count from 800h to 7FFh. At all other times it is low.
- R5: `neg_o` equals bit 11 of the count. `mag_o` equals (4096 - count) mod 4096 when `neg_o` is 1, and equals the count when `neg_o` is 0.
- R6: When the count is 800h (the most negative value), `neg_o` is 1 and `mag_o` is 800h.
- R7: `seg_mag_o[7*i+6:7*i]` holds the code for hex digit i of `mag_o`, where digit 0 is the least significant. Each code is active-low with bit 6 = g down to bit 0 = a. The codes for digits 0 to F are 40h, 79h, 24h, 30h, 19h, 12h, 02h, 78h, 00h, 10h, 08h, 03h, 46h, 21h, 06h, 0Eh.
- R8: `seg_sign_o` is 3Fh (minus sign) when the count is negative and 7Fh (blank) otherwise.
- R9: When the count is 000h, the three magnitude digits each show 40h and the sign digit shows 7Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; one step down per enabled edge |
| count_o | output | 12 | Raw two's complement count |
| neg_o | output | 1 | Sign of the count |
| mag_o | output | 12 | Unsigned magnitude of the count |
| seg_mag_o | output | 21 | Three active-low digit codes, digit 0 in bits 6:0 |
| seg_sign_o | output | 7 | Active-low minus-sign or blank code |
| ovf_o | output | 1 | One-cycle pulse after the wrap from 800h to 7FFh |

## Verification
The assertions take for granted that `en` is a clean synchronous level that is known at every rising edge once the internal reset has released. They also assume that `rst_n` is not toggled within a clock edge. The bench changes `en` only on falling edges and draws it from a seeded random source. `rst_n` is applied only at the start, while `en` is held low. A long enabled run takes the count through the wrap at 800h twice and back to zero, so the overflow and boundary checks are reached together with the random hold cycles.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned SEG_W = 7;
  localparam int unsigned NIB_W = 4;

  localparam logic [SEG_W-1:0] SEG_MINUS = 7'b0111111;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'b1111111;

  function automatic logic [SEG_W-1:0] hex_to_seg(input logic [NIB_W-1:0] nib);
    logic [SEG_W-1:0] s;
    case (nib)
      4'h0: s = 7'b1000000;
      4'h1: s = 7'b1111001;
      4'h2: s = 7'b0100100;
      4'h3: s = 7'b0110000;
      4'h4: s = 7'b0011001;
      4'h5: s = 7'b0010010;
      4'h6: s = 7'b0000010;
      4'h7: s = 7'b1111000;
      4'h8: s = 7'b0000000;
      4'h9: s = 7'b0010000;
      4'hA: s = 7'b0001000;
      4'hB: s = 7'b0000011;
      4'hC: s = 7'b1000110;
      4'hD: s = 7'b0100001;
      4'hE: s = 7'b0000110;
      default: s = 7'b0001110;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sdc_rst_sync.sv
module sdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/sdc_count_core.sv
module sdc_count_core #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         en,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = ~MOST_NEG;
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q - ONE;
    ovf_d = en && (cnt_q == MOST_NEG);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    en |=> cnt_q == $past(cnt_q) - ONE);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> $stable(cnt_q));
  // R4
  ovf_value_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ovf_q |-> cnt_q == MOST_POS);
  // R4
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/sdc_sign_mag.sv
module sdc_sign_mag #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] val_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  always_comb begin
    neg_o = val_i[W-1];
    mag_o = neg_o ? (~val_i + {{(W-1){1'b0}}, 1'b1}) : val_i;
  end
endmodule

// File: rtl/sdc_hex_seg.sv
module sdc_hex_seg
  import sdc_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SEG_W-1:0] seg_o
);
  always_comb seg_o = hex_to_seg(nib_i);
endmodule

// File: rtl/sdc_signed_down_counter.sv
module sdc_signed_down_counter
  import sdc_pkg::*;
#(
  parameter int unsigned W = 12,
  localparam int unsigned NDIG = W / NIB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  output logic [W-1:0]          count_o,
  output logic                  neg_o,
  output logic [W-1:0]          mag_o,
  output logic [NDIG*SEG_W-1:0] seg_mag_o,
  output logic [SEG_W-1:0]      seg_sign_o,
  output logic                  ovf_o
);
  logic rst_int_n;

  sdc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_sync_n(rst_int_n)
  );

  sdc_count_core #(.W(W)) u_core (
    .clk   (clk),
    .arst_n(rst_int_n),
    .en    (en),
    .cnt_o (count_o),
    .ovf_o (ovf_o)
  );

  sdc_sign_mag #(.W(W)) u_sm (
    .val_i(count_o),
    .neg_o(neg_o),
    .mag_o(mag_o)
  );

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    sdc_hex_seg u_seg (
      .nib_i(mag_o[i*NIB_W +: NIB_W]),
      .seg_o(seg_mag_o[i*SEG_W +: SEG_W])
    );
  end

  assign seg_sign_o = neg_o ? SEG_MINUS : SEG_BLANK;

  // R6
  mag_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mag_o[W-1] |-> (mag_o[W-2:0] == '0) && neg_o);
  // R8
  sign_seg_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (count_o[W-1] == 1'b0) |-> seg_sign_o == SEG_BLANK);
  // R9
  zero_disp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (count_o == '0) |-> !neg_o && (mag_o == '0));
endmodule

// File: tb/sdc_signed_down_counter_bench.sv
module sdc_signed_down_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [11:0] count_o, mag_o;
  logic        neg_o, ovf_o;
  logic [20:0] seg_mag_o;
  logic [6:0]  seg_sign_o;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_cnt;
  logic        exp_ovf;

  always #10 clk = ~clk;

  sdc_signed_down_counter u_sdc_signed_down_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .count_o(count_o), .neg_o(neg_o),
    .mag_o(mag_o), .seg_mag_o(seg_mag_o), .seg_sign_o(seg_sign_o), .ovf_o(ovf_o)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] d);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[d];
  endfunction

  function automatic logic [11:0] ref_mag(input logic [11:0] v);
    return v[11] ? 12'(13'd4096 - {1'b0, v}) : v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [11:0] m;
    m = ref_mag(exp_cnt);
    chk({req, " count"}, 32'(count_o), 32'(exp_cnt));
    chk("R4 ovf", 32'(ovf_o), 32'(exp_ovf));
    chk("R5 neg", 32'(neg_o), 32'(exp_cnt[11]));
    chk("R5 mag", 32'(mag_o), 32'(m));
    for (int i = 0; i < 3; i++)
      chk("R7 digit", 32'(seg_mag_o[7*i +: 7]), 32'(ref_seg(m[4*i +: 4])));
    chk("R8 sign", 32'(seg_sign_o), exp_cnt[11] ? 32'h3F : 32'h7F);
    if (exp_cnt == 12'h800) chk("R6 most negative mag", 32'(mag_o), 32'h800);
    if (exp_cnt == 12'h000) begin
      chk("R9 zero sign", 32'(seg_sign_o), 32'h7F);
      chk("R9 zero digits", 32'(seg_mag_o), {11'd0, 7'h40, 7'h40, 7'h40});
    end
  endtask

  // Called at a falling edge; applies e, crosses one rising edge, checks at next falling edge.
  task automatic tick(input logic e);
    en = e;
    @(posedge clk);
    exp_ovf = e && (exp_cnt == 12'h800);
    if (e) exp_cnt = exp_cnt - 12'd1;
    @(negedge clk);
    check_all(e ? "R2" : "R3");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    en = 1'b0;
    exp_cnt = '0;
    exp_ovf = 1'b0;
    #5;
    check_all("R1");
    repeat (3) @(negedge clk);
    check_all("R1");
    en = 1'b1;
    rst_n = 1'b1;
    // R1: two synchroniser edges keep the count at zero
    @(posedge clk); @(negedge clk); check_all("R1");
    @(posedge clk); @(negedge clk); check_all("R1");
    // directed: hold, then first step 000 -> FFF
    tick(1'b0);
    tick(1'b1);
    // random mix
    for (int k = 0; k < 3000; k++) tick(($urandom % 4) != 0);
    // directed: run through 800h wrap twice and past zero
    for (int k = 0; k < 8300; k++) tick(1'b1);
    // directed: hold exactly on 800h
    while (exp_cnt != 12'h800) tick(1'b1);
    tick(1'b0);
    tick(1'b0);
    tick(1'b1);
    tick(1'b0);
    for (int k = 0; k < 2000; k++) tick(($urandom % 2) != 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule